// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Flags

This block produces one interrupt line for each side of a two-port shared memory. The two highest addresses of the memory's address range serve as mailboxes, one for each direction. When one side writes its outgoing mailbox address, the interrupt line of the other side goes active. That receiving side later reads the same address to acknowledge, which returns its line to the inactive level. The mailbox words themselves live in the ordinary memory array; this block only watches the access strobes and addresses of both sides.

The block is synchronous to one clock. It samples each side's chip select, read/write select, output enable and address on every rising edge. A set is taken when a write access to a mailbox begins. A clear is taken when the acknowledging read access ends, whichever of its qualifying conditions drops first. Both interrupt lines are active low and always driven to a defined level.

Top module: `mbox_irq`

## Requirements
- R1: While reset (rst_n low) is applied, and after it is released, both interrupt outputs l_int_n and r_int_n are 1 (inactive) until a set occurs.
- R2: A left write access (l_cs_n=0, l_rw=0) to the top address (all address bits 1, 0x7FFF for 15 bits) drives r_int_n to 0 from the rising edge that first samples that access.
- R3: A right read access (r_cs_n=0, r_rw=1, r_oe_n=0) to the top address clears r_int_n to 1 at the first rising edge that samples the read access ended; while the read is still active the line stays 0.
- R4: A right write access (r_cs_n=0, r_rw=0) to the address one below the top (0x7FFE for 15 bits) drives l_int_n to 0 from the edge that first samples that access.
- R5: A left read access (l_cs_n=0, l_rw=1, l_oe_n=0) to the address one below the top clears l_int_n to 1 at the first edge that samples the read ended.
- R6: A mailbox access with the output enable inactive (oe_n=1), or with chip select inactive, neither clears nor sets an interrupt.
- R7: Accesses to any other address, a side writing the mailbox it reads, or a side reading the mailbox it writes, leave both interrupt outputs unchanged.
- R8: One write access sets an interrupt once: a write held over several cycles does not set the interrupt again after it has been cleared.
- R9: When a set and a clear of the same interrupt fall on the same edge, the set wins and the line stays 0.
- R10: The two directions are independent: both interrupts may be active at once, and one side's traffic does not change the other direction's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left chip select, active low |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| r_cs_n | input | 1 | Right chip select, active low |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| l_int_n | output | 1 | Interrupt to the left side, active low |
| r_int_n | output | 1 | Interrupt to the right side, active low |

## Verification
A wrong flag state shows directly on the matching interrupt pin at the edge after the access that should have moved it, so every check samples one clock after the relevant start or end of an access. A lost set appears as a line that stays high after a mailbox write; a stuck set appears as a line that stays low one edge after the acknowledging read has ended. Errors in the edge detectors show up as a repeated set during a held write or a clear taken while the read is still in progress, both of which the stimulus provokes on purpose, together with the same-edge set and clear.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_int_n,
  output logic              r_int_n
);

  localparam logic [ADDR_W-1:0] BOX_TO_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_TO_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_wr, l_rd, r_wr, r_rd;
  assign l_wr = !l_cs_n && !l_rw;
  assign l_rd = !l_cs_n &&  l_rw && !l_oe_n;
  assign r_wr = !r_cs_n && !r_rw;
  assign r_rd = !r_cs_n &&  r_rw && !r_oe_n;

  logic post_r, ack_r, post_l, ack_l;
  assign post_r = l_wr && (l_addr == BOX_TO_R);
  assign ack_r  = r_rd && (r_addr == BOX_TO_R);
  assign post_l = r_wr && (r_addr == BOX_TO_L);
  assign ack_l  = l_rd && (l_addr == BOX_TO_L);

  logic post_r_q, ack_r_q, post_l_q, ack_l_q;
  always_ff @(posedge clk) begin
    post_r_q <= post_r;
    ack_r_q  <= ack_r;
    post_l_q <= post_l;
    ack_l_q  <= ack_l;
  end

  logic set_r, clr_r, set_l, clr_l;
  assign set_r = post_r && !post_r_q;
  assign clr_r = ack_r_q && !ack_r;
  assign set_l = post_l && !post_l_q;
  assign clr_l = ack_l_q && !ack_l;

  logic flag_r, flag_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r <= 1'b0;
      flag_l <= 1'b0;
    end else begin
      if (set_r)      flag_r <= 1'b1;
      else if (clr_r) flag_r <= 1'b0;
      if (set_l)      flag_l <= 1'b1;
      else if (clr_l) flag_l <= 1'b0;
    end
  end

  assign r_int_n = !flag_r;
  assign l_int_n = !flag_l;

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_cs_n,
  input logic              l_rw,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs_n,
  input logic              r_rw,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_int_n,
  input logic              r_int_n
);

  logic lw_hi, rr_hi, rw_lo, lr_lo;
  assign lw_hi = !l_cs_n && !l_rw && (&l_addr);
  assign rr_hi = !r_cs_n && r_rw && !r_oe_n && (&r_addr);
  assign rw_lo = !r_cs_n && !r_rw && (&r_addr[ADDR_W-1:1]) && !r_addr[0];
  assign lr_lo = !l_cs_n && l_rw && !l_oe_n && (&l_addr[ADDR_W-1:1]) && !l_addr[0];

  always @(negedge clk)
    if (!rst_n) AST_RESET_IDLE: assert (l_int_n && r_int_n); // R1

  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_hi && !$past(lw_hi)) |=> !r_int_n); // R2

  AST_RIGHT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rr_hi) && !rr_hi && !(lw_hi && !$past(lw_hi))) |=> r_int_n); // R3

  AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_lo && !$past(rw_lo)) |=> !l_int_n); // R4

  AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lr_lo) && !lr_lo && !(rw_lo && !$past(rw_lo))) |=> l_int_n); // R5

  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lw_hi && !$past(lw_hi)) && !($past(rr_hi) && !rr_hi)) |=> $stable(r_int_n)); // R7

  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rw_lo && !$past(rw_lo)) && !($past(lr_lo) && !lr_lo)) |=> $stable(l_int_n)); // R7

endmodule

bind mbox_irq mbox_irq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/mbox_irq_tb.sv
module mbox_irq_tb_top;
  localparam int AW = 15;
  localparam logic [AW-1:0] TOP = 15'h7FFF;
  localparam logic [AW-1:0] NXT = 15'h7FFE;

  function automatic logic [17:0] pk(input logic cs_n, input logic rw,
                                     input logic oe_n, input logic [AW-1:0] a);
    return {cs_n, rw, oe_n, a};
  endfunction

  function automatic logic [37:0] row(input logic [17:0] l, input logic [17:0] r,
                                      input logic el, input logic er);
    return {l, r, el, er};
  endfunction

  localparam logic [17:0] ID    = pk(1'b1, 1'b1, 1'b1, '0);
  localparam logic [17:0] W_TOP = pk(1'b0, 1'b0, 1'b1, TOP);
  localparam logic [17:0] W_NXT = pk(1'b0, 1'b0, 1'b1, NXT);
  localparam logic [17:0] R_TOP = pk(1'b0, 1'b1, 1'b0, TOP);
  localparam logic [17:0] R_NXT = pk(1'b0, 1'b1, 1'b0, NXT);
  localparam logic [17:0] R_NOE = pk(1'b0, 1'b1, 1'b1, NXT);
  localparam logic [17:0] R_OTH = pk(1'b0, 1'b1, 1'b0, 15'h7FFD);
  localparam logic [17:0] W_OTH = pk(1'b0, 1'b0, 1'b1, 15'h0000);

  localparam int NV = 34;
  localparam logic [37:0] VEC [NV] = '{
    row(ID,    ID,    1, 1), // R1 idle
    row(W_TOP, ID,    1, 0), // R2 left posts to right
    row(W_TOP, ID,    1, 0), // R2 held
    row(ID,    ID,    1, 0), // R7 hold
    row(ID,    R_TOP, 1, 0), // R3 read in progress
    row(ID,    ID,    1, 1), // R3 read ended clears
    row(ID,    W_NXT, 0, 1), // R4 right posts to left
    row(R_NOE, ID,    0, 1), // R6 no output enable
    row(ID,    ID,    0, 1), // R6
    row(R_OTH, ID,    0, 1), // R7 other address
    row(ID,    ID,    0, 1), // R7
    row(ID,    R_NXT, 0, 1), // R7 right reads left box
    row(ID,    ID,    0, 1), // R7
    row(W_NXT, ID,    0, 1), // R7 left writes its own box
    row(ID,    ID,    0, 1), // R7
    row(R_NXT, ID,    0, 1), // R5 read in progress
    row(ID,    ID,    1, 1), // R5 cleared
    row(ID,    W_TOP, 1, 1), // R7 right writes its own box
    row(ID,    W_OTH, 1, 1), // R7 other address write
    row(W_TOP, ID,    1, 0), // R9 setup
    row(ID,    R_TOP, 1, 0), // R9 ack read
    row(W_TOP, ID,    1, 0), // R9 set and clear same edge
    row(ID,    ID,    1, 0), // R9 set held
    row(ID,    R_TOP, 1, 0), // R9
    row(ID,    ID,    1, 1), // R9 cleared
    row(W_TOP, ID,    1, 0), // R8 long write
    row(W_TOP, R_TOP, 1, 0), // R8
    row(W_TOP, ID,    1, 1), // R8 cleared, no re-set
    row(W_TOP, ID,    1, 1), // R8 still held
    row(ID,    ID,    1, 1), // R8
    row(W_TOP, W_NXT, 0, 0), // R10 both directions
    row(ID,    R_TOP, 0, 0), // R10
    row(ID,    ID,    0, 1), // R10 only right cleared
    row(R_NXT, ID,    0, 1)  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n, l_rw, l_oe_n, r_cs_n, r_rw, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_int_n, r_int_n;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) dut_i (.*);

  task automatic drive(input logic [17:0] l, input logic [17:0] r);
    {l_cs_n, l_rw, l_oe_n, l_addr} = l;
    {r_cs_n, r_rw, r_oe_n, r_addr} = r;
  endtask

  task automatic check(input string req, input logic el, input logic er);
    checks++;
    if (l_int_n !== el || r_int_n !== er) begin
      fails++;
      $display("FAIL %s: got l_int_n=%b r_int_n=%b expected %b %b",
               req, l_int_n, r_int_n, el, er);
    end
  endtask

  initial begin
    drive(ID, ID);
    repeat (3) @(negedge clk);
    check("R1", 1, 1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][37:20], VEC[i][19:2]);
      @(posedge clk);
      #1;
      check($sformatf("R%0s row %0d", "vec", i), VEC[i][1], VEC[i][0]);
    end
    // R1: reset in the middle of pending interrupts
    @(negedge clk); drive(W_TOP, W_NXT);
    @(negedge clk); drive(ID, ID);
    #1 check("R10 before reset", 0, 0);
    rst_n = 1'b0;
    #1 check("R1 async reset", 1, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", 1, 1);
    // R6: chip select inactive on a mailbox write
    @(negedge clk); drive(pk(1'b1, 1'b0, 1'b1, TOP), ID);
    @(posedge clk); #1 check("R6 cs inactive write", 1, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule